// File: doc/BRIEF.md
# Serial LSB-First Modulo-5 Detector

This block watches a binary number that arrives one bit at a time, with the least significant bit first. After each accepted bit it reports whether the value built so far is a multiple of five. The number has no width limit. The block never stores the bits. It keeps only the running remainder modulo 5 and the place weight of the next bit, also reduced modulo 5.

Each new bit at position k adds 2^k to the value. The residue of 2^k modulo 5 repeats with period four: 1, 2, 4, 3. The block therefore keeps a two-bit phase counter that steps once per accepted bit, and maps the phase to its weight. A bit of one adds that weight to the remainder, modulo 5. A bit of zero leaves the remainder alone but still moves the phase on. The divisibility flag is registered, so it reflects the new bit one clock after that bit is presented. A synchronous reset starts a new number whose value is empty, which counts as zero.

Top module: `div5_lsb_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the number is cleared. From the next edge on, `divisible` is 1 and the next accepted bit has weight 1.
- R2: When `bit_valid` is 1 at a rising edge, `bit_in` (1 meaning binary one) is taken as the next more significant bit. After that edge, `divisible` is 1 exactly when the value of all accepted bits is a multiple of 5.
- R3: When `bit_valid` is 0 at a rising edge, `bit_in` is ignored. The flag, the remainder and the position of the next bit all keep their values.
- R4: The accepted bit at position k (counting from 0) has weight 2^k mod 5, which follows 1, 2, 4, 3 and then repeats. A single one at any position, after only zeros, makes the value not divisible. A second one two places higher makes it divisible again.
- R5: Accepting a zero bit never changes `divisible`, so zeros added at the most significant end leave the result unchanged.
- R6: Zeros accepted before any one keep `divisible` at 1. A pattern that follows n leading zeros gives the same result as the pattern alone.
- R7: The result stays correct for streams of hundreds of bits, far longer than any register width. No limit applies to the stream length.
- R8: A reset in the middle of a stream discards all earlier bits. The next bit again has weight 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset that starts a new number |
| bit_valid | input | 1 | High when `bit_in` holds a bit to accept on this edge |
| bit_in | input | 1 | Serial data bit, least significant first |
| divisible | output | 1 | Registered flag: value received so far is a multiple of 5 |

## Verification
Single ones placed at positions 0 to 11 check the period-four weight sequence. Each is followed by a one two places higher, which distinguishes a correct weight table from one that only gets the first residues right. Long runs of zeros at the least significant end and at the most significant end confirm that the phase advances on zeros while the remainder stays put. Gaps with `bit_valid` low and a toggling `bit_in` show that idle cycles neither shift the weight nor disturb the flag. Long random streams with random idle gaps, plus a reset in mid-stream, are compared against a reference that doubles the weight for every bit.

// File: rtl/div5_pkg.sv
package div5_pkg;

    localparam int unsigned MODULUS  = 5;
    localparam int unsigned REM_W    = $clog2(MODULUS);
    localparam int unsigned PHASE_N  = 4;
    localparam int unsigned PHASE_W  = $clog2(PHASE_N);

    localparam logic [REM_W:0] SUM_MOD = (REM_W+1)'(MODULUS);

    typedef logic [REM_W-1:0] rem_t;

    // Phase names carry the weight 2^k mod 5 they stand for
    typedef enum logic [PHASE_W-1:0] {
        PH_W1 = 2'd0,
        PH_W2 = 2'd1,
        PH_W4 = 2'd2,
        PH_W3 = 2'd3
    } phase_e;

    typedef struct packed {
        rem_t   rem;
        phase_e phase;
    } acc_t;

    function automatic rem_t phase_weight(input phase_e p);
        case (p)
            PH_W1:   return rem_t'(1);
            PH_W2:   return rem_t'(2);
            PH_W4:   return rem_t'(4);
            default: return rem_t'(3);
        endcase
    endfunction

    function automatic phase_e phase_next(input phase_e p);
        case (p)
            PH_W1:   return PH_W2;
            PH_W2:   return PH_W4;
            PH_W4:   return PH_W3;
            default: return PH_W1;
        endcase
    endfunction

    // Both operands are below MODULUS, so one conditional subtract suffices
    function automatic rem_t mod_add(input rem_t a, input rem_t b);
        logic [REM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= SUM_MOD) s = s - SUM_MOD;
        return rem_t'(s);
    endfunction

endpackage

// File: rtl/div5_phase_track.sv
module div5_phase_track
    import div5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_W1;
        else if (advance)
            phase_q <= phase_next(phase_q);
    end

    assign phase = phase_q;

endmodule

// File: rtl/div5_rem_step.sv
module div5_rem_step
    import div5_pkg::*;
(
    input  rem_t   rem_in,
    input  phase_e phase,
    input  logic   data_bit,
    output rem_t   rem_out
);

    rem_t weight;

    always_comb begin
        weight  = phase_weight(phase);
        rem_out = data_bit ? mod_add(rem_in, weight) : rem_in;
    end

endmodule

// File: rtl/div5_lsb_detector.sv
module div5_lsb_detector
    import div5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic divisible
);

    acc_t acc;
    rem_t rem_q;
    rem_t rem_d;
    logic flag_q;

    div5_phase_track u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (bit_valid),
        .phase   (acc.phase)
    );

    div5_rem_step u_step (
        .rem_in   (rem_q),
        .phase    (acc.phase),
        .data_bit (bit_in),
        .rem_out  (rem_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            flag_q <= 1'b1;
        end else if (bit_valid) begin
            rem_q  <= rem_d;
            flag_q <= (rem_d == '0);
        end
    end

    assign acc.rem   = rem_q;
    assign divisible = flag_q;

endmodule

// File: rtl/div5_checker.sv
module div5_checker
    import div5_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   bit_valid,
    input logic   bit_in,
    input logic   divisible,
    input phase_e phase,
    input rem_t   rem
);

    // R1: reset leaves an empty number with weight 1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (divisible && rem == '0 && phase == PH_W1));

    // R3: idle cycles hold flag, remainder and phase
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(divisible) && $stable(rem) && $stable(phase)));

    // R4: every accepted bit moves to the next weight
    a_r4_phase_moves: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> (phase != $past(phase)));

    // R4: a one after a divisible value always breaks divisibility
    a_r4_one_breaks: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in && divisible) |=> !divisible);

    // R5: a zero bit never changes the flag
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_in) |=> $stable(divisible));

    // R7: remainder stays inside the residue range
    a_r7_rem_range: assert property (@(posedge clk) disable iff (rst)
        rem < rem_t'(MODULUS));

endmodule

bind div5_lsb_detector div5_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .divisible (divisible),
    .phase     (acc.phase),
    .rem       (acc.rem)
);

// File: tb/tb_div5_lsb_detector.sv
module tb_div5_lsb_detector;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic divisible;

    int checks = 0;
    int errors = 0;
    int ref_rem = 0;
    int ref_w = 1;

    div5_lsb_detector dut (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .divisible (divisible)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        bit_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ref_rem = 0;
        ref_w = 1;
        check(divisible, 1'b1, req);
    endtask

    // Presents one bit at a falling edge and checks the flag one edge later
    task automatic push(input logic b, input string req);
        bit_valid = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
        if (b) ref_rem = (ref_rem + ref_w) % 5;
        ref_w = (ref_w * 2) % 5;
        check(divisible, ref_rem == 0, req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b0;
            bit_in = 1'($urandom);
            @(negedge clk);
            check(divisible, ref_rem == 0, req);
        end
    endtask

    task automatic t_reset();
        do_reset("R1 flag after reset");
        push(1'b1, "R1 first bit weight 1");
        check(divisible, 1'b0, "R1 value 1 not divisible");
    endtask

    task automatic t_known();
        do_reset("R2 reset");
        push(1'b1, "R2 value 1");
        push(1'b0, "R2 value 1");
        push(1'b1, "R2 value 5");
        check(divisible, 1'b1, "R2 value 5 divisible");
        push(1'b1, "R2 value 13");
        check(divisible, 1'b0, "R2 value 13 not divisible");
    endtask

    task automatic t_weight();
        for (int k = 0; k < 12; k++) begin
            do_reset("R4 reset");
            for (int z = 0; z < k; z++) push(1'b0, "R4 zero prefix");
            push(1'b1, "R4 single one");
            check(divisible, 1'b0, "R4 lone power of two");
            push(1'b0, "R4 gap");
            push(1'b1, "R4 one two places up");
            check(divisible, 1'b1, "R4 five times power of two");
        end
    endtask

    task automatic t_idle();
        do_reset("R3 reset");
        push(1'b1, "R3 bit");
        idle(5, "R3 idle after one");
        push(1'b0, "R3 bit");
        idle(3, "R3 idle after zero");
        push(1'b1, "R3 bit");
        check(divisible, 1'b1, "R3 weight not advanced by idle");
    endtask

    task automatic t_lsb_zeros();
        do_reset("R6 reset");
        for (int i = 0; i < 9; i++) begin
            push(1'b0, "R6 leading zero");
            check(divisible, 1'b1, "R6 zero value divisible");
        end
        push(1'b1, "R6 pattern");
        push(1'b0, "R6 pattern");
        push(1'b1, "R6 pattern");
        check(divisible, 1'b1, "R6 shifted five divisible");
    endtask

    task automatic t_msb_zeros();
        logic kept;
        do_reset("R5 reset");
        push(1'b1, "R5 prefix");
        push(1'b1, "R5 prefix");
        kept = divisible;
        for (int i = 0; i < 10; i++) begin
            push(1'b0, "R5 high zero");
            check(divisible, kept, "R5 high zeros keep flag");
        end
    endtask

    task automatic t_long(input int n);
        do_reset("R7 reset");
        for (int i = 0; i < n; i++) begin
            push(1'($urandom), "R7 long stream");
            if (($urandom % 8) == 0) idle(1 + ($urandom % 3), "R3 random gap");
            if (i == n / 2) begin
                do_reset("R8 reset mid-stream");
                push(1'b1, "R8 weight 1 after reset");
                check(divisible, 1'b0, "R8 old bits discarded");
            end
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_known();
        t_weight();
        t_idle();
        t_lsb_zeros();
        t_msb_zeros();
        t_long(700);
        t_long(400);
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
        $finish;
    end

endmodule